// File: doc/BRIEF.md
# Dual-Port Sample Demultiplexer with Data Sync

This block runs on the sample clock and accepts one conversion word with its overrange flag on every rising edge. It spreads that stream across two output ports, A and B, taking turns, so each port carries half the sample rate. A half-rate data clock comes out with the ports and marks which port holds the newest word, so downstream logic can latch the two ports with it.

The sync input controls both the phase of the split and freezing of the outputs. While it is high, the ports and the data clock hold their values and every word already in the pipeline is discarded. The first edge at which it is seen low again picks the sample that goes to port B. The sample after it goes to port A. The mode input selects one of two output timings. In interleaved timing both ports have the same latency and change on alternate edges. In parallel timing port A has one extra stage, so both ports change on the same edge. The format input selects offset binary or two's complement coding of the output words.

Top module: `dmx_top`

## Requirements
- R1: Words captured on consecutive edges are sent to alternate ports, so each port takes a new word at most once every two edges.
- R2: `dataClk` becomes 1 on every edge where port B loads a word. It becomes 0 on every edge where a word bound for port A reaches the output stage. It holds its value on all other edges.
- R3: On an edge where `syncIn` is high, `portAData`, `portBData`, both overrange flags and `dataClk` keep their values, and every word in flight is discarded.
- R4: On the first edge with `syncIn` low after it was high, the sample captured goes to port B and the next sample goes to port A.
- R5: With `parMode` = 0 (interleaved), a sample captured on edge N appears on its port after edge N+6, for both ports.
- R6: With `parMode` = 1 (parallel), port B has a latency of 6 edges and port A a latency of 7 edges, so both ports change on the same edge, and `dataClk` is 1 after that edge.
- R7: With `twosFmt` = 0, the output word equals the input word (offset binary). With `twosFmt` = 1, bit 9 (the MSB) is inverted and the other bits are unchanged (two's complement). The format is taken on the capture edge.
- R8: Each port's overrange flag is the `overIn` value captured with the word that port carries.
- R9: Synchronous active-low reset clears both ports, both flags and `dataClk` to 0. After reset the first sample captured goes to port B.
- R10: After reset or a sync release, both ports hold their values until the first new word arrives at its port. No word from before is ever shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| sampleIn | input | 10 | Conversion word in offset binary |
| overIn | input | 1 | Overrange flag of `sampleIn` |
| syncIn | input | 1 | Freezes the outputs while high; release sets the port phase |
| parMode | input | 1 | 0 = interleaved timing, 1 = parallel timing |
| twosFmt | input | 1 | 0 = offset binary, 1 = two's complement |
| portAData | output | 10 | Port A word |
| portAOver | output | 1 | Port A overrange flag |
| portBData | output | 10 | Port B word |
| portBOver | output | 1 | Port B overrange flag |
| dataClk | output | 1 | Half-rate data clock aligned to the ports |

## Verification
The hardest case to reach is a sync pulse that arrives while the pipeline is full. Words captured before the pulse must never reach a port, and the first word after the release must land on port B exactly six edges later. Each scenario first runs a stream, then holds sync high for several edges while the input keeps changing. It then releases sync on a known sample and checks every following edge against the latency of the selected mode. The scenarios cover both modes and both formats, with sample values chosen so that the MSB changes inside the stream.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic capture;  // take the input word into the pipeline
    logic toA;      // captured word is bound for port A (else port B)
    logic flush;    // freeze outputs and discard in-flight words
  } dmxStrobes_t;
endpackage

// File: rtl/dmx_ctrl.sv
module dmx_ctrl
  import dmx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncIn,
  output dmxStrobes_t str
);
  logic phaseQ;

  always_ff @(posedge clk) begin
    if (!rstN)       phaseQ <= 1'b0;
    else if (syncIn) phaseQ <= 1'b0;
    else             phaseQ <= ~phaseQ;
  end

  always_comb begin
    str.capture = ~syncIn;
    str.toA     = phaseQ;
    str.flush   = syncIn;
  end

  // R1: consecutive captures go to opposite ports
  p_alternate_r1: assert property (@(posedge clk) disable iff (!rstN)
    str.capture |=> (!str.capture || (str.toA != $past(str.toA))));

  // R4: first capture after sync release is bound for port B
  p_sync_first_b_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncIn) |-> (str.capture && !str.toA));
endmodule

// File: rtl/dmx_datapath.sv
module dmx_datapath
  import dmx_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int LAT    = 6
)(
  input  logic              clk,
  input  logic              rstN,
  input  dmxStrobes_t       str,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              overIn,
  input  logic              parMode,
  input  logic              twosFmt,
  output logic [DATA_W-1:0] portAData,
  output logic              portAOver,
  output logic [DATA_W-1:0] portBData,
  output logic              portBOver,
  output logic              dataClk
);
  localparam int WORD_W = DATA_W + 1;
  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  logic [LAT-1:0]    vld;
  logic [LAT-1:0]    tag;
  logic [WORD_W-1:0] word [LAT];

  logic              holdV;
  logic [WORD_W-1:0] holdWord;
  logic [WORD_W-1:0] portAWord, portBWord;
  logic              dataClkQ;

  logic              lastV, lastTag;
  logic [WORD_W-1:0] lastWord;

  // Capture stage: apply format and tag the destination port
  always_ff @(posedge clk) begin
    if (!rstN) vld[0] <= 1'b0;
    else       vld[0] <= str.capture;
    tag[0]  <= str.toA;
    word[0] <= {overIn, twosFmt ? (sampleIn ^ MSB_MASK) : sampleIn};
  end

  // Delay stages; a flush clears every valid bit
  for (genvar s = 1; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN || str.flush) vld[s] <= 1'b0;
      else                    vld[s] <= vld[s-1];
      tag[s]  <= tag[s-1];
      word[s] <= word[s-1];
    end
  end

  assign lastV    = vld[LAT-1];
  assign lastTag  = tag[LAT-1];
  assign lastWord = word[LAT-1];

  // Extra port A stage used in parallel timing
  always_ff @(posedge clk) begin
    if (!rstN || str.flush) holdV <= 1'b0;
    else                    holdV <= lastV && lastTag;
    if (lastV && lastTag) holdWord <= lastWord;
  end

  // Output registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      portAWord <= '0;
      portBWord <= '0;
      dataClkQ  <= 1'b0;
    end else if (!str.flush) begin
      if (lastV && !lastTag) portBWord <= lastWord;
      if (parMode) begin
        if (holdV) portAWord <= holdWord;
      end else if (lastV && lastTag) begin
        portAWord <= lastWord;
      end
      if (lastV) dataClkQ <= ~lastTag;
    end
  end

  assign portAData = portAWord[DATA_W-1:0];
  assign portAOver = portAWord[DATA_W];
  assign portBData = portBWord[DATA_W-1:0];
  assign portBOver = portBWord[DATA_W];
  assign dataClk   = dataClkQ;

  // R3: outputs frozen across a sync-high edge
  p_freeze_r3: assert property (@(posedge clk) disable iff (!rstN)
    str.flush |=> ($stable(portAWord) && $stable(portBWord) && $stable(dataClkQ)));

  // R2: a new port B word always comes with the data clock high
  p_b_clk_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(portBWord) |-> dataClkQ);

  // R5: interleaved, port A changes as the data clock falls
  p_int_a_edge_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!parMode && !$past(parMode) && !$stable(portAWord)) |-> $fell(dataClkQ));

  // R6: parallel, port A changes on the edge where the data clock rises
  p_par_a_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    (parMode && $past(parMode) && !$stable(portAWord)) |-> $rose(dataClkQ));
endmodule

// File: rtl/dmx_top.sv
module dmx_top
  import dmx_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int LAT    = 6
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              overIn,
  input  logic              syncIn,
  input  logic              parMode,
  input  logic              twosFmt,
  output logic [DATA_W-1:0] portAData,
  output logic              portAOver,
  output logic [DATA_W-1:0] portBData,
  output logic              portBOver,
  output logic              dataClk
);
  dmxStrobes_t str;

  dmx_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .syncIn (syncIn),
    .str    (str)
  );

  dmx_datapath #(.DATA_W(DATA_W), .LAT(LAT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .str       (str),
    .sampleIn  (sampleIn),
    .overIn    (overIn),
    .parMode   (parMode),
    .twosFmt   (twosFmt),
    .portAData (portAData),
    .portAOver (portAOver),
    .portBData (portBData),
    .portBOver (portBOver),
    .dataClk   (dataClk)
  );
endmodule

// File: tb/tb_dmx_top.sv
module tb_dmx_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] sampleIn = '0;
  logic         overIn = 1'b0;
  logic         syncIn = 1'b0;
  logic         parMode = 1'b0;
  logic         twosFmt = 1'b0;
  logic [W-1:0] portAData, portBData;
  logic         portAOver, portBOver, dataClk;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmx_top dut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .overIn(overIn),
    .syncIn(syncIn), .parMode(parMode), .twosFmt(twosFmt),
    .portAData(portAData), .portAOver(portAOver),
    .portBData(portBData), .portBOver(portBOver), .dataClk(dataClk)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R7: offset binary passes through; two's complement flips bit 9
  function automatic logic [W-1:0] fmt(int v, bit twos);
    logic [W-1:0] t;
    t = v[W-1:0];
    return twos ? (t ^ 10'h200) : t;
  endfunction

  function automatic logic ovrOf(int v);
    return (v % 3) == 0;
  endfunction

  // One scenario: freeze (or reset), release on sample 'base', follow 12 edges
  task automatic runSeq(bit par, bit twos, int base, bit viaReset);
    logic [W-1:0] fa, fb;
    logic fc, foa, fob;
    int aLat;
    int j;
    aLat = par ? 7 : 6;
    @(negedge clk);
    parMode = par;
    twosFmt = twos;
    if (viaReset) begin
      rstN = 1'b0;
      syncIn = 1'b0;
      repeat (2) @(negedge clk);
      chk("R9 reset portA", portAData, 0);
      chk("R9 reset portB", portBData, 0);
      chk("R9 reset flags", {portAOver, portBOver}, 0);
      chk("R9 reset dataClk", dataClk, 0);
    end else begin
      syncIn = 1'b1;
    end
    fa = portAData; fb = portBData; fc = dataClk;
    foa = portAOver; fob = portBOver;
    if (!viaReset) begin
      for (int i = 0; i < 3; i++) begin
        sampleIn = W'(base * 7 + i * 91);
        overIn = ~overIn;
        @(negedge clk);
        chk("R3 freeze portA", portAData, fa);
        chk("R3 freeze portB", portBData, fb);
        chk("R3 freeze dataClk", dataClk, fc);
        chk("R3 freeze flags", {portAOver, portBOver}, {foa, fob});
      end
    end
    rstN = 1'b1;
    syncIn = 1'b0;
    for (int k = 0; k < 12; k++) begin
      sampleIn = W'(base + k);
      overIn = ovrOf(base + k);
      @(negedge clk);
      // port B: even offsets, latency 6 (R1 R4 R5 R6)
      if (k < 6) begin
        chk("R10 hold portB", portBData, fb);
        chk("R10 hold flagB", portBOver, fob);
      end else begin
        j = ((k - 6) / 2) * 2;
        chk("R1 R4 R7 portB", portBData, fmt(base + j, twos));
        chk("R8 flagB", portBOver, ovrOf(base + j));
      end
      // port A: odd offsets, latency 6 interleaved or 7 parallel
      if (k < aLat + 1) begin
        chk("R10 hold portA", portAData, fa);
        chk("R10 hold flagA", portAOver, foa);
      end else begin
        j = ((k - aLat - 1) / 2) * 2 + 1;
        if (par) chk("R6 R7 portA", portAData, fmt(base + j, twos));
        else     chk("R5 R7 portA", portAData, fmt(base + j, twos));
        chk("R8 flagA", portAOver, ovrOf(base + j));
      end
      // data clock
      if (k < 6) chk("R2 dataClk hold", dataClk, fc);
      else       chk("R2 dataClk phase", dataClk, ((k - 6) % 2) == 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    runSeq(1'b0, 1'b0, 10'h1FC, 1'b1);
    runSeq(1'b0, 1'b1, 1018, 1'b0);
    runSeq(1'b1, 1'b0, 10'h1FD, 1'b0);
    runSeq(1'b1, 1'b1, 20, 1'b0);
    runSeq(1'b1, 1'b0, 300, 1'b1);
    runSeq(1'b0, 1'b0, 77, 1'b0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end
endmodule